// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces one interrupt per port for a memory shared by a left and a right port. It does not hold any message data; it only watches the access strobes and addresses that both ports present to the shared array. The two highest addresses are reserved as mailboxes. The all-ones address belongs to the right port, and the address one below it belongs to the left port. When one port writes into the other port's mailbox, the owner's interrupt asserts. The owner drops its interrupt by reading its own mailbox.

Each port has a chip select, a write strobe, an output enable, an address and a busy input that comes from the contention arbiter. A port whose busy input is high has lost arbitration. That port can neither raise the other side's interrupt nor drop its own. Both interrupt outputs are registered and active low. The address width is a parameter, and the two mailbox addresses are derived from it.

Top module: `mbx_irq_top`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, both lt_irq_n and rt_irq_n are 1 (inactive).
- R2: A cycle with lt_cs=1, lt_we=1, lt_busy=0 and lt_addr equal to all ones drives rt_irq_n to 0 after the next rising clock edge.
- R3: A cycle with rt_cs=1, rt_we=1, rt_busy=0 and rt_addr equal to all ones minus one drives lt_irq_n to 0 after the next rising clock edge.
- R4: An owner read clears that port's interrupt at the next edge, so its irq_n returns to 1. An owner read needs cs=1, we=0, oe=1 and busy=0 at the port's own mailbox address. A read with oe=0 does not clear it.
- R5: A port reading the other port's mailbox leaves the other port's interrupt unchanged.
- R6: While a port's busy input is 1, its writes to the opposite mailbox do not assert the opposite interrupt.
- R7: While a port's busy input is 1, its reads of its own mailbox do not clear its own interrupt.
- R8: If a set and a clear of the same interrupt fall in the same cycle, the interrupt is asserted (0) after that edge.
- R9: Writes by a port to its own mailbox, and accesses to any address below the two mailboxes, change neither interrupt.
- R10: An interrupt output changes only as a result of a set or a clear access; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_cs | input | 1 | Left port select, active high |
| lt_we | input | 1 | Left port write (1) or read (0) |
| lt_oe | input | 1 | Left port output enable, active high |
| lt_addr | input | ADDR_W | Left port address |
| lt_busy | input | 1 | Left port lost arbitration, active high |
| rt_cs | input | 1 | Right port select, active high |
| rt_we | input | 1 | Right port write (1) or read (0) |
| rt_oe | input | 1 | Right port output enable, active high |
| rt_addr | input | ADDR_W | Right port address |
| rt_busy | input | 1 | Right port lost arbitration, active high |
| lt_irq_n | output | 1 | Interrupt to the left port, active low |
| rt_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
Directed sequences set each flag by a cross write and then try every way it could wrongly change. These include a reader on the wrong side, a read with the output enable low, a read while busy, a write while busy, a write to the port's own mailbox and an address just below the mailboxes. Each attempt tells a correct mailbox decode apart from one that swaps sides or ignores a qualifier. One cycle sets and clears the same flag at once, which tells set priority from clear priority. A long random phase then biases addresses toward the two top locations and mixes all strobes and busy levels. A bench model predicts every cycle, which exposes any condition that the directed cases missed.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

   typedef enum logic [0:0] {
      SIDE_LT = 1'b0,
      SIDE_RT = 1'b1
   } mbx_side_e;

   typedef struct packed {
      logic cs;
      logic we;
      logic oe;
      logic busy;
   } mbx_ctl_t;

   // Write that is allowed to touch a flag
   function automatic logic ctl_wr_ok(mbx_ctl_t c);
      return c.cs & c.we & ~c.busy;
   endfunction

   // Read that drives data out and is allowed to touch a flag
   function automatic logic ctl_rd_ok(mbx_ctl_t c);
      return c.cs & ~c.we & c.oe & ~c.busy;
   endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
   import mbx_irq_pkg::*;
#(
   parameter int        ADDR_W = 12,
   parameter mbx_side_e SIDE   = SIDE_LT
) (
   input  mbx_ctl_t           ctl,
   input  logic [ADDR_W-1:0]  addr,
   output logic               set_peer,
   output logic               clr_own
);

   localparam logic [ADDR_W-1:0] TOP_BOX  = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] NEXT_BOX = TOP_BOX - 1'b1;

   logic [ADDR_W-1:0] own_box;
   logic [ADDR_W-1:0] peer_box;

   generate
      if (SIDE == SIDE_RT) begin : g_rt
         assign own_box  = TOP_BOX;
         assign peer_box = NEXT_BOX;
      end else begin : g_lt
         assign own_box  = NEXT_BOX;
         assign peer_box = TOP_BOX;
      end
   endgenerate

   always_comb begin
      set_peer = ctl_wr_ok(ctl) && (addr == peer_box);
      clr_own  = ctl_rd_ok(ctl) && (addr == own_box);
   end

endmodule

// File: rtl/mbx_flag_reg.sv
module mbx_flag_reg #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq_n
);

   logic flag_q;
   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_first
         assign flag_d = set | (flag_q & ~clr);
      end else begin : g_clr_first
         assign flag_d = ~clr & (flag_q | set);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign irq_n = ~flag_q;

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
   import mbx_irq_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lt_cs,
   input  logic              lt_we,
   input  logic              lt_oe,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic              lt_busy,
   input  logic              rt_cs,
   input  logic              rt_we,
   input  logic              rt_oe,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic              rt_busy,
   output logic              lt_irq_n,
   output logic              rt_irq_n
);

   localparam int NSIDE = 2;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mbx_irq_top: ADDR_W must be at least 2");
      end
   endgenerate

   mbx_ctl_t          ctl  [NSIDE];
   logic [ADDR_W-1:0] addr [NSIDE];
   logic [NSIDE-1:0]  set_peer;
   logic [NSIDE-1:0]  clr_own;
   logic [NSIDE-1:0]  irq_n;

   assign ctl[SIDE_LT]  = '{cs: lt_cs, we: lt_we, oe: lt_oe, busy: lt_busy};
   assign ctl[SIDE_RT]  = '{cs: rt_cs, we: rt_we, oe: rt_oe, busy: rt_busy};
   assign addr[SIDE_LT] = lt_addr;
   assign addr[SIDE_RT] = rt_addr;

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         mbx_port_decode #(
            .ADDR_W (ADDR_W),
            .SIDE   (mbx_side_e'(s))
         ) dec_i (
            .ctl      (ctl[s]),
            .addr     (addr[s]),
            .set_peer (set_peer[s]),
            .clr_own  (clr_own[s])
         );

         // this side's flag is raised by the opposite side
         mbx_flag_reg #(
            .SET_WINS (SET_WINS)
         ) flag_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_peer[NSIDE-1-s]),
            .clr   (clr_own[s]),
            .irq_n (irq_n[s])
         );
      end
   endgenerate

   assign lt_irq_n = irq_n[SIDE_LT];
   assign rt_irq_n = irq_n[SIDE_RT];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lt_cs,
   input logic              lt_we,
   input logic              lt_oe,
   input logic [ADDR_W-1:0] lt_addr,
   input logic              lt_busy,
   input logic              rt_cs,
   input logic              rt_we,
   input logic              rt_oe,
   input logic [ADDR_W-1:0] rt_addr,
   input logic              rt_busy,
   input logic              lt_irq_n,
   input logic              rt_irq_n
);

   localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

   logic l_hits_rt, r_hits_lt, l_reads_own, r_reads_own;
   assign l_hits_rt   = lt_cs && lt_we && !lt_busy && (lt_addr == HI);
   assign r_hits_lt   = rt_cs && rt_we && !rt_busy && (rt_addr == LO);
   assign l_reads_own = lt_cs && !lt_we && lt_oe && !lt_busy && (lt_addr == LO);
   assign r_reads_own = rt_cs && !rt_we && rt_oe && !rt_busy && (rt_addr == HI);

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (lt_irq_n && rt_irq_n));

   assert_rt_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      l_hits_rt |=> !rt_irq_n);

   assert_lt_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      r_hits_lt |=> !lt_irq_n);

   assert_rt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (r_reads_own && !l_hits_rt) |=> rt_irq_n);

   assert_lt_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (l_reads_own && !r_hits_lt) |=> lt_irq_n);

   assert_lt_busy_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_busy && rt_irq_n) |=> rt_irq_n);

   assert_rt_busy_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_busy && lt_irq_n) |=> lt_irq_n);

   assert_rt_busy_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_busy && !rt_irq_n) |=> !rt_irq_n);

   assert_lt_busy_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_busy && !lt_irq_n) |=> !lt_irq_n);

   assert_rt_fall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && $past(rst_n) && $fell(rt_irq_n)) |-> $past(l_hits_rt));

   assert_lt_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && $past(rst_n) && $rose(lt_irq_n)) |-> $past(l_reads_own));

endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .lt_cs    (lt_cs),
   .lt_we    (lt_we),
   .lt_oe    (lt_oe),
   .lt_addr  (lt_addr),
   .lt_busy  (lt_busy),
   .rt_cs    (rt_cs),
   .rt_we    (rt_we),
   .rt_oe    (rt_oe),
   .rt_addr  (rt_addr),
   .rt_busy  (rt_busy),
   .lt_irq_n (lt_irq_n),
   .rt_irq_n (rt_irq_n)
);

// File: tb/mbx_irq_top_tb.sv
module mbx_irq_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 12;
   localparam logic [AW-1:0] HI = {AW{1'b1}};
   localparam logic [AW-1:0] LO = HI - 1'b1;

   logic clk = 1'b0;
   logic rst_n;
   logic lt_cs, lt_we, lt_oe, lt_busy;
   logic rt_cs, rt_we, rt_oe, rt_busy;
   logic [AW-1:0] lt_addr, rt_addr;
   logic lt_irq_n, rt_irq_n;

   int n_chk  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;
   bit exp_lt = 1'b0;  // 1 = left interrupt asserted
   bit exp_rt = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_irq_top #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lt_cs(lt_cs), .lt_we(lt_we), .lt_oe(lt_oe), .lt_addr(lt_addr), .lt_busy(lt_busy),
      .rt_cs(rt_cs), .rt_we(rt_we), .rt_oe(rt_oe), .rt_addr(rt_addr), .rt_busy(rt_busy),
      .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
   );

   function automatic bit wr_at(bit cs, bit we, bit b, logic [AW-1:0] a, logic [AW-1:0] t);
      return cs && we && !b && (a == t);
   endfunction

   function automatic bit rd_at(bit cs, bit we, bit oe, bit b, logic [AW-1:0] a, logic [AW-1:0] t);
      return cs && !we && oe && !b && (a == t);
   endfunction

   function automatic bit next_flag(bit cur, bit set, bit clr);
      return set ? 1'b1 : (clr ? 1'b0 : cur);
   endfunction

   task automatic check(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(bit lcs, bit lwe, bit loe, bit lb, logic [AW-1:0] la,
                       bit rcs, bit rwe, bit roe, bit rb, logic [AW-1:0] ra, string tag);
      lt_cs = lcs; lt_we = lwe; lt_oe = loe; lt_busy = lb; lt_addr = la;
      rt_cs = rcs; rt_we = rwe; rt_oe = roe; rt_busy = rb; rt_addr = ra;
      exp_rt = next_flag(exp_rt, wr_at(lcs, lwe, lb, la, HI), rd_at(rcs, rwe, roe, rb, ra, HI));
      exp_lt = next_flag(exp_lt, wr_at(rcs, rwe, rb, ra, LO), rd_at(lcs, lwe, loe, lb, la, LO));
      @(posedge clk);
      @(negedge clk);
      check({tag, " lt_irq_n"}, lt_irq_n, !exp_lt);
      check({tag, " rt_irq_n"}, rt_irq_n, !exp_rt);
   endtask

   task automatic idle(string tag);
      step(0,0,0,0,'0, 0,0,0,0,'0, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      lt_cs = 0; lt_we = 0; lt_oe = 0; lt_busy = 0; lt_addr = '0;
      rt_cs = 0; rt_we = 0; rt_oe = 0; rt_busy = 0; rt_addr = '0;
      repeat (3) @(negedge clk);
      check("R1 reset lt", lt_irq_n, 1'b1);
      check("R1 reset rt", rt_irq_n, 1'b1);
      rst_n = 1'b1;
      idle("R1 after reset");

      step(1,1,0,0,HI, 0,0,0,0,'0, "R2 left write sets right");
      step(1,0,1,0,HI, 0,0,0,0,'0, "R5 left reads right box");
      step(0,0,0,0,'0, 1,0,0,0,HI, "R4 read without oe");
      step(0,0,0,0,'0, 1,0,1,1,HI, "R7 right busy read");
      step(0,0,0,0,'0, 1,0,1,0,HI, "R4 right owner read");
      step(1,1,0,1,HI, 0,0,0,0,'0, "R6 left busy write");
      step(0,0,0,0,'0, 1,1,0,1,LO, "R6 right busy write");
      step(0,0,0,0,'0, 1,1,0,0,LO, "R3 right write sets left");
      step(0,0,0,0,'0, 1,0,1,0,LO, "R5 right reads left box");
      step(1,0,1,0,LO, 1,1,0,0,LO, "R8 set and clear together");
      step(1,1,0,0,LO, 0,0,0,0,'0, "R9 left writes own box");
      step(1,1,0,0,LO-1'b1, 1,1,0,0,HI, "R9 below box and own write");
      repeat (3) idle("R10 hold");
      step(1,0,1,1,LO, 0,0,0,0,'0, "R7 left busy read");
      step(1,0,1,0,LO, 0,0,0,0,'0, "R4 left owner read");
      step(1,1,0,0,HI, 1,0,1,0,HI, "R8 right set wins");

      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] la, ra;
         int pl, pr;
         pl = $urandom_range(0, 9);
         pr = $urandom_range(0, 9);
         la = (pl < 4) ? HI : (pl < 8) ? LO : AW'($urandom);
         ra = (pr < 4) ? HI : (pr < 8) ? LO : AW'($urandom);
         step(1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0,3) == 0), la,
              1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0,3) == 0), ra,
              "R10 random mix");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule